// File: doc/BRIEF.md
# Tag System Queue Engine

This block runs a tag system in hardware. Its whole state is a queue of symbols plus a table of productions, with one production for each symbol value. A step reads the symbol at the head of the queue, takes the production for that symbol from the table, removes a fixed number of symbols (two by default) from the head, and then adds the production's symbols at the tail, one per cycle. No control state survives from one step to the next: the head symbol alone selects what happens.

Software first loads the initial word into the queue and programs the production table. These loads are accepted only while the engine is idle or halted. A start pulse then begins the run. The engine stops in one of two cases: fewer symbols remain than one step removes, or the head holds the reserved halt symbol. After it stops, the remaining queue contents can be read through an offset read port. If an append would exceed the queue depth, the engine stops and raises a sticky overflow flag that only reset clears.

The controller has six states:
- `ST_IDLE`: after reset; loads and rule writes are accepted.
- `ST_CHECK`: tests the halt condition and latches the head's production.
- `ST_DELETE`: removes the head symbols.
- `ST_APPEND`: writes one production symbol per cycle.
- `ST_HALT`: stopped normally; loads, rule writes and restart are accepted.
- `ST_ERROR`: overflow; stays there until reset.

The transitions are:
- IDLE/HALT→CHECK on `start`.
- CHECK→HALT when the halt condition holds.
- CHECK→DELETE when `step_en` is high.
- DELETE→CHECK for an empty production, DELETE→APPEND otherwise.
- APPEND→CHECK after the last symbol.
- APPEND→ERROR when the queue is full.

Top module: `tag_engine`

## Requirements
- R1: After reset, `busy`, `halted` and `overflow` are 0 and `q_count` is 0.
- R2: In ST_IDLE or ST_HALT, each cycle with `load_en` high adds `load_sym` at the tail. `rd_sym` shows the symbol `rd_off` places behind the head, where offset 0 is the head.
- R3: Each step looks up the production of the head symbol as it was before the step. It then removes DEL_CNT (2) symbols from the head and adds the production's symbols at the tail. Symbol k of a production is `rule_word[k*SYM_W +: SYM_W]`, and symbol 0 is added first.
- R4: The engine halts (`halted`=1, `busy`=0) when `q_count` is less than DEL_CNT at the start of a step.
- R5: The engine halts when the head symbol equals HALT_SYM (0 by default), and leaves the queue unchanged in that step.
- R6: While `step_en` is low, the engine waits before the next step, with `busy` high and the queue unchanged.
- R7: An append into a full queue sets `overflow`, which stays set until reset. It also stops the engine with `busy` low, and `start` is ignored from then on.
- R8: `load_en` and `rule_we` are ignored while `busy` is high. A rule write with `rule_len` greater than MAX_LEN is ignored.
- R9: A production of length 0 performs only the removal.
- R10: The append phase adds one symbol per cycle. From the start edge, a single step with production length L followed by a halt raises `halted` L+3 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Add `load_sym` at the queue tail |
| load_sym | input | SYM_W | Symbol to load |
| rule_we | input | 1 | Write one production |
| rule_head | input | SYM_W | Head symbol whose production is written |
| rule_len | input | LEN_W | Production length |
| rule_word | input | MAX_LEN*SYM_W | Production symbols, symbol 0 in the low bits |
| start | input | 1 | Begin or resume a run |
| step_en | input | 1 | Allow the next step |
| rd_off | input | PTR_W | Read offset from the head |
| rd_sym | output | SYM_W | Symbol at `rd_off` |
| q_count | output | PTR_W+1 | Number of symbols in the queue |
| busy | output | 1 | Run in progress |
| halted | output | 1 | Stopped by the halt condition |
| overflow | output | 1 | Sticky queue overflow |

## Verification
The step rule is exercised in several ways, each compared with an independent queue model in the bench:
- A three-rule Collatz-style rule set started from two different word lengths. This separates correct head-based rule selection and append order from off-by-one removal.
- A rule set whose productions place the halt symbol at the head partway through a run. This checks that the halt symbol stops the machine, as distinct from running out of symbols.
- Empty productions, which check removal on its own.
- A production that always grows the word, which drives the queue into overflow.

A single-step timing run checks the per-symbol append rate. A paused run checks that loads and rule writes issued while busy leave no trace.

// File: rtl/tag_pkg.sv
package tag_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_DELETE,
        ST_APPEND,
        ST_HALT,
        ST_ERROR
    } tag_state_e;
endpackage

// File: rtl/tag_queue.sv
module tag_queue #(
    parameter int SYM_W   = 3,
    parameter int DEPTH   = 64,
    parameter int DEL_CNT = 2,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [SYM_W-1:0] push_sym,
    input  logic             pop,
    input  logic [PTR_W-1:0] rd_off,
    output logic [SYM_W-1:0] rd_sym,
    output logic [SYM_W-1:0] head_sym,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] DEL_C   = CNT_W'(DEL_CNT);
    localparam logic [PTR_W-1:0] DEL_P   = PTR_W'(DEL_CNT);

    logic [SYM_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             do_push;

    assign full    = (cnt == DEPTH_C);
    assign do_push = push && !full;
    assign count   = cnt;
    assign rd_sym  = mem[rd_ptr + rd_off];
    assign head_sym = mem[rd_ptr];

    always_comb begin
        cnt_nxt = cnt;
        if (do_push) cnt_nxt = cnt_nxt + 1'b1;
        if (pop)     cnt_nxt = cnt_nxt - DEL_C;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_sym;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)     rd_ptr <= rd_ptr + DEL_P;
            cnt <= cnt_nxt;
        end
    end

    // Removal only happens when enough symbols are present.
    assert_pop_has_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt >= DEL_C));
    // The controller never pushes into a full queue.
    assert_no_write_into_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full));
    assert_count_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= DEPTH_C);
endmodule

// File: rtl/tag_rules.sv
module tag_rules #(
    parameter int SYM_W   = 3,
    parameter int MAX_LEN = 4,
    localparam int NSYM   = 2 ** SYM_W,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int WORD_W = MAX_LEN * SYM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SYM_W-1:0]  wr_head,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [SYM_W-1:0]  rd_head,
    output logic [LEN_W-1:0]  rd_len,
    output logic [WORD_W-1:0] rd_word
);
    localparam logic [LEN_W-1:0] MAX_C = LEN_W'(MAX_LEN);

    logic [LEN_W-1:0]  len_mem  [NSYM];
    logic [WORD_W-1:0] word_mem [NSYM];
    logic              wr_ok;

    assign wr_ok   = we && (wr_len <= MAX_C);
    assign rd_len  = len_mem[rd_head];
    assign rd_word = word_mem[rd_head];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSYM; i++) len_mem[i] <= '0;
        end else if (wr_ok) begin
            len_mem[wr_head] <= wr_len;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) word_mem[wr_head] <= wr_word;
    end

    assert_len_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_len <= MAX_C);
endmodule

// File: rtl/tag_engine.sv
module tag_engine
    import tag_pkg::*;
#(
    parameter int SYM_W    = 3,
    parameter int DEPTH    = 64,
    parameter int MAX_LEN  = 4,
    parameter int DEL_CNT  = 2,
    parameter int HALT_SYM = 0,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int CNT_W   = PTR_W + 1,
    localparam int LEN_W   = $clog2(MAX_LEN + 1),
    localparam int WORD_W  = MAX_LEN * SYM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [SYM_W-1:0]  load_sym,
    input  logic              rule_we,
    input  logic [SYM_W-1:0]  rule_head,
    input  logic [LEN_W-1:0]  rule_len,
    input  logic [WORD_W-1:0] rule_word,
    input  logic              start,
    input  logic              step_en,
    input  logic [PTR_W-1:0]  rd_off,
    output logic [SYM_W-1:0]  rd_sym,
    output logic [CNT_W-1:0]  q_count,
    output logic              busy,
    output logic              halted,
    output logic              overflow
);
    localparam logic [CNT_W-1:0] DEL_C  = CNT_W'(DEL_CNT);
    localparam logic [SYM_W-1:0] HALT_C = SYM_W'(HALT_SYM);

    tag_state_e        state, nxt;
    logic [LEN_W-1:0]  prod_len, lut_len;
    logic [WORD_W-1:0] prod_word, lut_word;
    logic [LEN_W-1:0]  idx;
    logic [SYM_W-1:0]  head_sym, push_sym;
    logic              q_push, q_pop, q_full;
    logic              idle_like, stop_cond, take_step, last_sym;

    assign idle_like = (state == ST_IDLE) || (state == ST_HALT);
    assign stop_cond = (q_count < DEL_C) || (head_sym == HALT_C);
    assign take_step = (state == ST_CHECK) && !stop_cond && step_en;
    assign last_sym  = (idx == prod_len - LEN_W'(1));

    tag_queue #(.SYM_W(SYM_W), .DEPTH(DEPTH), .DEL_CNT(DEL_CNT)) queue_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (q_push),
        .push_sym (push_sym),
        .pop      (q_pop),
        .rd_off   (rd_off),
        .rd_sym   (rd_sym),
        .head_sym (head_sym),
        .count    (q_count),
        .full     (q_full)
    );

    tag_rules #(.SYM_W(SYM_W), .MAX_LEN(MAX_LEN)) rules_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rule_we && idle_like),
        .wr_head (rule_head),
        .wr_len  (rule_len),
        .wr_word (rule_word),
        .rd_head (head_sym),
        .rd_len  (lut_len),
        .rd_word (lut_word)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_HALT: if (start) nxt = ST_CHECK;
            ST_CHECK: begin
                if (stop_cond)    nxt = ST_HALT;
                else if (step_en) nxt = ST_DELETE;
            end
            ST_DELETE: nxt = (prod_len == '0) ? ST_CHECK : ST_APPEND;
            ST_APPEND: begin
                if (q_full)        nxt = ST_ERROR;
                else if (last_sym) nxt = ST_CHECK;
            end
            ST_ERROR: nxt = ST_ERROR;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Outputs and queue controls
    always_comb begin
        q_push   = 1'b0;
        q_pop    = 1'b0;
        push_sym = load_sym;
        unique case (state)
            ST_IDLE, ST_HALT: q_push = load_en;
            ST_DELETE:        q_pop  = 1'b1;
            ST_APPEND: begin
                q_push   = !q_full;
                push_sym = prod_word[idx*SYM_W +: SYM_W];
            end
            default: ;
        endcase
        busy     = (state == ST_CHECK) || (state == ST_DELETE) || (state == ST_APPEND);
        halted   = (state == ST_HALT);
        overflow = (state == ST_ERROR);
    end

    // Production latch and append index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_len  <= '0;
            prod_word <= '0;
            idx       <= '0;
        end else if (take_step) begin
            prod_len  <= lut_len;
            prod_word <= lut_word;
            idx       <= '0;
        end else if (state == ST_APPEND && !q_full) begin
            idx <= idx + 1'b1;
        end
    end

    assert_delete_removes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DELETE) |=> (q_count == $past(q_count) - DEL_C));
    assert_append_grows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_APPEND && !q_full) |=> (q_count == $past(q_count) + 1'b1));
    assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> (overflow && !busy));
    assert_pause_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && !step_en) |=> $stable(q_count));
    assert_halt_reason_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> ((q_count < DEL_C) || (head_sym == HALT_C)));
    assert_one_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, halted, overflow}));
endmodule

// File: tb/tag_engine_tb.sv
module tag_engine_tb_top;
    localparam int SYM_W = 3, DEPTH = 64, MAX_LEN = 4;
    localparam int PTR_W = 6, CNT_W = 7, LEN_W = 3, WORD_W = 12;

    logic              clk = 1'b0, rst_n = 1'b0;
    logic              load_en = 0, rule_we = 0, start = 0, step_en = 1;
    logic [SYM_W-1:0]  load_sym = '0, rule_head = '0;
    logic [LEN_W-1:0]  rule_len = '0;
    logic [WORD_W-1:0] rule_word = '0;
    logic [PTR_W-1:0]  rd_off = '0;
    logic [SYM_W-1:0]  rd_sym;
    logic [CNT_W-1:0]  q_count;
    logic              busy, halted, overflow;

    int n_chk = 0, n_fail = 0;
    int m_len [8];
    int m_word [8][4];
    int mq [$];
    int m_ovf;

    always #5 clk = ~clk;

    tag_engine dut_i (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_sym(load_sym),
        .rule_we(rule_we), .rule_head(rule_head), .rule_len(rule_len),
        .rule_word(rule_word), .start(start), .step_en(step_en),
        .rd_off(rd_off), .rd_sym(rd_sym), .q_count(q_count),
        .busy(busy), .halted(halted), .overflow(overflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; load_en = 0; rule_we = 0; start = 0; step_en = 1;
        for (int i = 0; i < 8; i++) m_len[i] = 0;
        mq.delete();
        m_ovf = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic prog_rule(input int h, input int len, input int w0, input int w1,
                             input int w2, input int w3);
        @(negedge clk);
        rule_we = 1; rule_head = SYM_W'(h); rule_len = LEN_W'(len);
        rule_word = {SYM_W'(w3), SYM_W'(w2), SYM_W'(w1), SYM_W'(w0)};
        if (len <= MAX_LEN) begin
            m_len[h] = len;
            m_word[h][0] = w0; m_word[h][1] = w1; m_word[h][2] = w2; m_word[h][3] = w3;
        end
        @(negedge clk);
        rule_we = 0;
    endtask

    task automatic load(input int s);
        @(negedge clk);
        load_en = 1; load_sym = SYM_W'(s);
        mq.push_back(s);
        @(negedge clk);
        load_en = 0;
    endtask

    task automatic model_run();
        for (int it = 0; it < 20000; it++) begin
            int h;
            if (mq.size() < 2 || mq[0] == 0) break;
            h = mq[0];
            void'(mq.pop_front());
            void'(mq.pop_front());
            for (int k = 0; k < m_len[h]; k++) begin
                if (mq.size() == DEPTH) begin m_ovf = 1; break; end
                mq.push_back(m_word[h][k]);
            end
            if (m_ovf) break;
        end
    endtask

    task automatic run_wait();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        for (int c = 0; c < 20000 && !halted && !overflow; c++) @(negedge clk);
    endtask

    task automatic cmp_queue(input string req);
        int bad = -1, a = 0, e = 0;
        chk({req, " count"}, int'(q_count), mq.size());
        chk({req, " overflow"}, int'(overflow), m_ovf);
        chk({req, " halted"}, int'(halted), 1 - m_ovf);
        for (int i = 0; i < mq.size() && i < DEPTH; i++) begin
            rd_off = PTR_W'(i);
            #1;
            if (bad < 0 && int'(rd_sym) != mq[i]) begin bad = i; a = rd_sym; e = mq[i]; end
        end
        chk({req, " contents"}, a, e);
    endtask

    task automatic collatz_rules();
        prog_rule(1, 2, 2, 3, 0, 0);
        prog_rule(2, 1, 1, 0, 0, 0);
        prog_rule(3, 3, 1, 1, 1, 0);
    endtask

    task automatic t_reset();
        do_reset(); @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 halted", int'(halted), 0);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 count", int'(q_count), 0);
    endtask

    task automatic t_load();
        do_reset();
        load(4); load(6); load(1); load(7); load(2);
        chk("R2 count", int'(q_count), 5);
        for (int i = 0; i < 5; i++) begin
            rd_off = PTR_W'(i); #1;
            chk("R2 readout", int'(rd_sym), mq[i]);
        end
    endtask

    task automatic t_collatz(input int n);
        do_reset(); collatz_rules();
        for (int i = 0; i < n; i++) load(1);
        model_run(); run_wait();
        cmp_queue("R3 R4 collatz");
    endtask

    task automatic t_halt_sym();
        do_reset();
        prog_rule(1, 2, 3, 3, 0, 0);
        prog_rule(3, 2, 0, 2, 0, 0);
        load(1); load(2); load(1); load(3);
        model_run(); run_wait();
        cmp_queue("R5 midrun");
        chk("R5 head is halt", int'(mq.size() >= 2 && mq[0] == 0), 1);
        do_reset(); collatz_rules();
        load(0); load(1); load(1);
        model_run(); run_wait();
        cmp_queue("R5 immediate");
    endtask

    task automatic t_single();
        do_reset(); collatz_rules(); load(1);
        model_run(); run_wait();
        cmp_queue("R4 short");
    endtask

    task automatic t_empty_prod();
        do_reset();
        prog_rule(2, 0, 0, 0, 0, 0);
        prog_rule(1, 2, 2, 2, 0, 0);
        load(2); load(5); load(1); load(5); load(2); load(6); load(1);
        model_run(); run_wait();
        cmp_queue("R9 empty production");
    endtask

    task automatic t_timing();
        int n = 0;
        do_reset();
        prog_rule(1, 3, 0, 4, 5, 0);
        load(1); load(7);
        @(negedge clk); start = 1;
        @(posedge clk);
        @(negedge clk); start = 0;
        while (!halted && n < 50) begin @(posedge clk); n++; @(negedge clk); end
        chk("R10 edges to halt", n, 6);
        chk("R10 count", int'(q_count), 3);
    endtask

    task automatic t_pause();
        do_reset(); collatz_rules();
        load(1); load(1); load(1);
        model_run();
        @(negedge clk); step_en = 0; start = 1;
        @(negedge clk); start = 0;
        repeat (10) @(negedge clk);
        chk("R6 busy while paused", int'(busy), 1);
        chk("R6 count while paused", int'(q_count), 3);
        load_en = 1; load_sym = 3;
        @(negedge clk); load_en = 0;
        rule_we = 1; rule_head = 1; rule_len = 1; rule_word = 12'd3;
        @(negedge clk); rule_we = 0;
        chk("R8 load ignored", int'(q_count), 3);
        step_en = 1;
        for (int c = 0; c < 20000 && !halted && !overflow; c++) @(negedge clk);
        cmp_queue("R8 R6 resumed");
    endtask

    task automatic t_bad_len();
        do_reset(); collatz_rules();
        prog_rule(1, 6, 5, 5, 5, 5);
        load(1); load(1); load(1);
        model_run(); run_wait();
        cmp_queue("R8 long rule ignored");
    endtask

    task automatic t_overflow();
        do_reset();
        prog_rule(1, 4, 1, 1, 1, 1);
        load(1); load(1);
        model_run(); run_wait();
        cmp_queue("R7 overflow");
        chk("R7 busy", int'(busy), 0);
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        repeat (3) @(negedge clk);
        chk("R7 sticky", int'(overflow), 1);
        chk("R7 start ignored", int'(busy), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_load();
        t_collatz(3);
        t_collatz(5);
        t_halt_sym();
        t_single();
        t_empty_prod();
        t_timing();
        t_pause();
        t_bad_len();
        t_overflow();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule